// File: doc/BRIEF.md
# Gray-Scale Pulse Phase Generator

This block turns a stored 6-bit gray level per column into a three-level drive sequence. Each column follows a frame of 128 counter-clock cycles. It first drives the negative level for a span set by its level. It then drives the positive level for exactly 64 cycles. It returns to the negative level until the frame is over, and then rests at ground. Gray scale is carried by where the fixed-width positive pulse sits inside the frame, not by how wide it is. One frame counter serves every column.

Frame requests arrive on a valid/ready handshake. A request carries the level bus for all columns. The levels are captured into per-column snapshot registers in the cycle the handshake completes, so the level inputs may change freely while a frame runs. Back-pressure: `frame_ready_o` is low while a frame is in progress, except during its final count. A requester keeps `frame_valid_i` and the level bus steady until it sees ready. A request accepted on the final count starts the next frame with no ground gap. The force-to-ground and invert controls are plain level inputs that act on the outputs without delay. They do not disturb the counter.

Top module: `grayscale_phase_gen`

## Requirements
- R1: Each column's 2-bit drive code is 2'b00 for ground, 2'b01 for the negative level and 2'b10 for the positive level. The code 2'b11 never appears.
- R2: During and after reset, before any request is accepted, every column drives ground and `frame_ready_o` is high.
- R3: An accepted request starts a frame of exactly 128 cycles, counted 0 to 127, beginning in the cycle after the handshake edge.
- R4: A column with level N drives the negative level for counts 0 through N, which is N+1 cycles (1 cycle for level 0, 64 cycles for level 63).
- R5: The same column then drives the positive level for exactly 64 cycles, counts N+1 through N+64.
- R6: The column drives the negative level for the counts left after the pulse, up to count 127. It drives ground in the first cycle after the frame unless a new frame has started.
- R7: `frame_ready_o` is low during counts 0 to 126 of a running frame. The levels used are those present at the handshake, and level inputs changed later have no effect on that frame.
- R8: A request accepted during count 127 starts a new frame at count 0 in the next cycle, using the newly captured levels.
- R9: While `force_gnd_i` is high, every column drives ground in the same cycle. The frame count keeps advancing, so output resumes at the correct position once the input falls.
- R10: While `invert_i` is high, positive and negative drive codes are swapped, and the timing is unchanged.
- R11: All columns share one frame counter, so columns with different levels follow the same frame alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_valid_i | input | 1 | Frame request valid |
| frame_ready_o | output | 1 | Request can be taken this cycle |
| level_i | input | NUM_COLS*LEVEL_W | Packed gray levels, column c at bits [c*LEVEL_W +: LEVEL_W] |
| force_gnd_i | input | 1 | Forces every column to ground |
| invert_i | input | 1 | Swaps positive and negative drive |
| drive_o | output | NUM_COLS*2 | Packed drive codes, column c at bits [2c +: 2] |

## Verification
Two events can fall in the same cycle: the end of one frame and the acceptance of the next. The bench raises a second request early in a running frame, with a different set of levels, and holds it against low ready. The request is taken on count 127. The bench then checks that the cycle after count 127 is already count 0 of the new frame under the new levels, with no ground cycle between the frames. It also checks that ready stayed low up to that point.

// File: rtl/gpg_pkg.sv
package gpg_pkg;

  typedef enum logic [1:0] {
    DRV_GND = 2'b00,
    DRV_NEG = 2'b01,
    DRV_POS = 2'b10
  } drive_e;

endpackage

// File: rtl/gpg_frame_seq.sv
module gpg_frame_seq #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = {CNT_W{1'b1}};

  logic             active_q;
  logic [CNT_W-1:0] count_q;
  logic             at_last;

  assign at_last  = active_q && (count_q == LAST_CNT);
  assign ready_o  = !active_q || at_last;
  assign accept_o = valid_i && ready_o;
  assign active_o = active_q;
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      count_q  <= '0;
    end else if (active_q) begin
      if (at_last) begin
        active_q <= 1'b0;
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  // R3: the count steps by one each cycle inside a frame
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !at_last && !valid_i) |=> (active_q && count_q == $past(count_q) + 1'b1));

  // R7: no request is taken in the middle of a frame
  a_r7_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && count_q != LAST_CNT) |-> !ready_o);

  // R8: an accept while running can only occur on the final count
  a_r8_chain_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && active_q) |=> (active_q && count_q == '0));

endmodule

// File: rtl/gpg_column.sv
module gpg_column
  import gpg_pkg::*;
#(
  parameter int unsigned LEVEL_W = 6,
  parameter int unsigned CNT_W   = LEVEL_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               active_i,
  input  logic [CNT_W-1:0]   count_i,
  output drive_e             phase_o
);

  localparam int unsigned    PULSE_LEN = 1 << LEVEL_W;
  localparam logic [CNT_W-1:0] PULSE_CNT = CNT_W'(PULSE_LEN);

  logic [LEVEL_W-1:0] snap_q;
  logic [CNT_W-1:0]   lead_end;
  logic [CNT_W-1:0]   since_lead;
  logic               in_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
    end else if (accept_i) begin
      snap_q <= level_i;
    end
  end

  assign lead_end   = {{(CNT_W-LEVEL_W){1'b0}}, snap_q};
  assign since_lead = count_i - lead_end;
  assign in_pulse   = (count_i > lead_end) && (since_lead <= PULSE_CNT);

  always_comb begin
    if (!active_i) begin
      phase_o = DRV_GND;
    end else if (in_pulse) begin
      phase_o = DRV_POS;
    end else begin
      phase_o = DRV_NEG;
    end
  end

  // R7: the captured level only changes on an accepted request
  a_r7_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(snap_q));

  // R4: count 0 of every frame is a negative-level cycle
  a_r4_first_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && count_i == '0) |-> (phase_o == DRV_NEG));

  // R6: outside a frame the column rests at ground
  a_r6_idle_ground: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (phase_o == DRV_GND));

endmodule

// File: rtl/gpg_polarity.sv
module gpg_polarity
  import gpg_pkg::*;
(
  input  drive_e     phase_i,
  input  logic       force_gnd_i,
  input  logic       invert_i,
  output logic [1:0] drive_o
);

  drive_e drive_sel;

  always_comb begin
    if (force_gnd_i) begin
      drive_sel = DRV_GND;
    end else if (invert_i) begin
      case (phase_i)
        DRV_POS: drive_sel = DRV_NEG;
        DRV_NEG: drive_sel = DRV_POS;
        default: drive_sel = DRV_GND;
      endcase
    end else begin
      drive_sel = phase_i;
    end
  end

  assign drive_o = drive_sel;

endmodule

// File: rtl/grayscale_phase_gen.sv
module grayscale_phase_gen
  import gpg_pkg::*;
#(
  parameter int unsigned NUM_COLS = 8,
  parameter int unsigned LEVEL_W  = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_valid_i,
  output logic                        frame_ready_o,
  input  logic [NUM_COLS*LEVEL_W-1:0] level_i,
  input  logic                        force_gnd_i,
  input  logic                        invert_i,
  output logic [NUM_COLS*2-1:0]       drive_o
);

  localparam int unsigned CNT_W = LEVEL_W + 1;

  logic             accept;
  logic             active;
  logic [CNT_W-1:0] count;

  gpg_frame_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (frame_valid_i),
    .ready_o  (frame_ready_o),
    .accept_o (accept),
    .active_o (active),
    .count_o  (count)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    drive_e phase;

    gpg_column #(
      .LEVEL_W (LEVEL_W),
      .CNT_W   (CNT_W)
    ) u_col (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept),
      .level_i  (level_i[c*LEVEL_W +: LEVEL_W]),
      .active_i (active),
      .count_i  (count),
      .phase_o  (phase)
    );

    gpg_polarity u_pol (
      .phase_i     (phase),
      .force_gnd_i (force_gnd_i),
      .invert_i    (invert_i),
      .drive_o     (drive_o[2*c +: 2])
    );

    // R1: the unused code never reaches a column output
    a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drive_o[2*c +: 2] != 2'b11);

    // R9: forcing grounds the column in the same cycle
    a_r9_force_ground: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_gnd_i |-> (drive_o[2*c +: 2] == 2'b00));

    // R10: inversion never turns a driven cycle into ground
    a_r10_invert_keeps_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!force_gnd_i && phase != DRV_GND) |-> (drive_o[2*c +: 2] != 2'b00));
  end

  // R2: with no frame running, every column is grounded
  a_r2_idle_all_ground: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (drive_o == '0));

endmodule

// File: tb/test_grayscale_phase_gen.sv
`timescale 1ns/1ps
module test_grayscale_phase_gen;

  localparam int NC = 8;
  localparam int LW = 6;
  typedef int lv_t[NC];

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              frame_valid_i = 1'b0;
  logic              frame_ready_o;
  logic [NC*LW-1:0]  level_i = '0;
  logic              force_gnd_i = 1'b0;
  logic              invert_i = 1'b0;
  logic [NC*2-1:0]   drive_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  grayscale_phase_gen #(.NUM_COLS(NC), .LEVEL_W(LW)) i_grayscale_phase_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .frame_ready_o (frame_ready_o),
    .level_i       (level_i),
    .force_gnd_i   (force_gnd_i),
    .invert_i      (invert_i),
    .drive_o       (drive_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(int lvl, int k, bit inv, bit frc);
    logic [1:0] code;
    if (frc || k > 127) return 2'b00;
    code = (k > lvl && k <= lvl + 64) ? 2'b10 : 2'b01;
    if (inv) code = (code == 2'b10) ? 2'b01 : 2'b10;
    return code;
  endfunction

  task automatic put_levels(input lv_t lv);
    for (int c = 0; c < NC; c++) level_i[c*LW +: LW] = LW'(lv[c]);
  endtask

  // Raise a request at a falling edge, wait for ready, return at count 0.
  task automatic start_frame(input lv_t lv);
    put_levels(lv);
    frame_valid_i = 1'b1;
    while (!frame_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    frame_valid_i = 1'b0;
  endtask

  // Walk counts 0..127 from the current falling edge and compare every column.
  task automatic check_frame(input lv_t lv, input bit inv, input int f_lo, input int f_hi,
                             input bit chain, input lv_t nxt, input string tag);
    int bad[NC];
    int bad_act[NC];
    int bad_exp[NC];
    for (int c = 0; c < NC; c++) bad[c] = -1;
    invert_i = inv;
    for (int k = 0; k < 128; k++) begin
      force_gnd_i = (k >= f_lo && k < f_hi);
      if (k == 3) begin
        if (chain) begin
          put_levels(nxt);
          frame_valid_i = 1'b1;
        end else begin
          for (int c = 0; c < NC; c++) level_i[c*LW +: LW] = ~LW'(lv[c]);
        end
      end
      #1;
      for (int c = 0; c < NC; c++) begin
        logic [1:0] e;
        e = exp_code(lv[c], k, inv, force_gnd_i);
        if (drive_o[2*c +: 2] !== e && bad[c] < 0) begin
          bad[c] = k;
          bad_act[c] = int'(drive_o[2*c +: 2]);
          bad_exp[c] = int'(e);
        end
      end
      if (k == 10) chk(frame_ready_o == 1'b0, {"R7 ready low mid-frame ", tag}, int'(frame_ready_o), 0);
      if (k == 127) chk(frame_ready_o == 1'b1, {"R7 ready high on final count ", tag}, int'(frame_ready_o), 1);
      @(negedge clk_i);
    end
    force_gnd_i = 1'b0;
    for (int c = 0; c < NC; c++) begin
      chk(bad[c] < 0, $sformatf("R1 R4 R5 R6 R11 %s col %0d first bad count %0d", tag, c, bad[c]),
          bad_act[c], bad_exp[c]);
    end
    if (chain) begin
      frame_valid_i = 1'b0;
    end else begin
      #1;
      chk(drive_o == '0, {"R6 ground after frame ", tag}, int'(drive_o), 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(drive_o == '0, "R2 ground in reset", int'(drive_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(drive_o == '0, "R2 ground after reset", int'(drive_o), 0);
    chk(frame_ready_o == 1'b1, "R2 ready after reset", int'(frame_ready_o), 1);
  endtask

  task automatic t_basic();
    lv_t lv = '{0, 63, 1, 62, 31, 32, 17, 5};
    start_frame(lv);
    check_frame(lv, 1'b0, -1, -1, 1'b0, lv, "basic");
  endtask

  task automatic t_chain();
    lv_t a = '{7, 40, 63, 0, 12, 50, 33, 2};
    lv_t b = '{63, 0, 20, 45, 9, 1, 60, 30};
    start_frame(a);
    check_frame(a, 1'b0, -1, -1, 1'b1, b, "R8 first of chained pair");
    check_frame(b, 1'b0, -1, -1, 1'b0, b, "R8 second of chained pair");
  endtask

  task automatic t_invert();
    lv_t lv = '{3, 58, 0, 63, 22, 44, 11, 36};
    start_frame(lv);
    check_frame(lv, 1'b1, -1, -1, 1'b0, lv, "R10 inverted");
    invert_i = 1'b0;
  endtask

  task automatic t_force();
    lv_t lv = '{10, 20, 30, 40, 50, 60, 0, 63};
    start_frame(lv);
    check_frame(lv, 1'b0, 35, 75, 1'b0, lv, "R9 forced window");
  endtask

  task automatic t_force_idle();
    force_gnd_i = 1'b1;
    invert_i = 1'b1;
    #1;
    chk(drive_o == '0, "R9 force while idle", int'(drive_o), 0);
    force_gnd_i = 1'b0;
    invert_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_chain();
    t_invert();
    t_force();
    t_force_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule